// File: doc/BRIEF.md
# Sequential Flash Line Prefetch Buffer

This block sits between a 32-bit processor fetch port and a flash array that delivers 128-bit lines, so one line holds four words. The array needs a selectable number of wait states before a line can be sampled. The block keeps two line buffers for instruction fetches and a third, separate line buffer for data reads. Requests that hit a buffer complete in a single cycle. While the processor works through one code line, the block reads the following line into the other code buffer. A straight run of code therefore does not stall at line boundaries, even with three wait states.

The processor side is a valid/ready handshake. The requester raises `req_valid` with `req_code` and a word-aligned `req_addr`, and must hold all three steady until it sees `req_ready`. The response word on `rsp_data` is valid only in the cycle where `req_valid` and `req_ready` are both high. The block never withdraws `req_ready` from a request once it is granted. The array side is a plain line read port: `fl_rd` with a line index on `fl_addr`, and the line returned on `fl_rdata`. A one-cycle `flush` pulse marks the completion of a program or erase operation elsewhere.

Top module: `fpb_top`

## Requirements
- R1: After reset, with no request presented, `req_ready` and `fl_rd` stay low.
- R2: The wait-state setting `ws_sel` selects 0 (code 0), 1 (code 1) or 3 (codes 2 and 3) wait states. A request that misses with the array port idle completes after ws+1 cycles, counting the cycle in which it is first presented.
- R3: In an unbroken run of code fetches to consecutive words starting at a line boundary, every word after the first completes in one cycle, line boundaries included, for every wait-state setting. The two code buffers never hold the same line.
- R4: The returned word is word `req_addr[3:2]` of line `req_addr[15:4]`. Within the 128-bit line, word w occupies bits 32*w+31 down to 32*w.
- R5: A data read that hits the data buffer completes in one cycle. A data read that misses, with the array port idle, completes in ws+1 cycles.
- R6: Filling the data buffer leaves both code buffers unchanged. A code line present before a data miss still hits in one cycle afterwards, and so does a prefetched code line.
- R7: A code fetch that misses both code buffers while a prefetch to a different line is in flight abandons that prefetch. It starts its own array read at once and completes in ws+1 cycles.
- R8: A `flush` pulse empties all three buffers. Afterwards, addresses that hit before complete in ws+1 cycles.
- R9: `req_ready` is only ever high while `req_valid` is high.
- R10: The block holds `fl_addr` steady for the full ws+1 cycles of an array read, unless that read is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ws_sel | input | 2 | Wait-state select: 0, 1, otherwise 3 |
| flush | input | 1 | Program/erase completion pulse, empties all buffers |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Request complete, `rsp_data` valid |
| req_code | input | 1 | 1 = instruction fetch, 0 = data read |
| req_addr | input | AW (16) | Byte address, word aligned |
| rsp_data | output | 32 | Returned word |
| fl_rd | output | 1 | Array line read active |
| fl_addr | output | AW-4 (12) | Line index being read |
| fl_rdata | input | 128 | Line returned by the array |

## Verification
The bench uses the default 16-bit address, which gives 4096 lines. It sweeps every `ws_sel` code, so the 0, 1 and 3 wait-state cases are each checked for cold-miss latency, sixteen-word sequential runs, data hits and misses, abandoned prefetches and flushes. The bench's array model returns a garbage pattern until the address has been held for the selected wait count. Early sampling or an unstable address therefore shows up as a wrong word. A seeded mixed sweep of code and data reads over 256 words compares every returned word with the arithmetic line pattern.

// File: rtl/fpb_pkg.sv
`timescale 1ns/1ps
package fpb_pkg;
  typedef enum logic [1:0] {
    TGT_C0 = 2'd0,
    TGT_C1 = 2'd1,
    TGT_D  = 2'd2
  } fill_tgt_e;

  function automatic logic [1:0] ws_decode(input logic [1:0] sel);
    case (sel)
      2'd0:    ws_decode = 2'd0;
      2'd1:    ws_decode = 2'd1;
      default: ws_decode = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/fpb_line_store.sv
`timescale 1ns/1ps
module fpb_line_store #(
  parameter int LA_W   = 12,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inv,
  input  logic              wr,
  input  logic [LA_W-1:0]   wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  output logic              valid,
  output logic [LA_W-1:0]   tag,
  output logic [LINE_W-1:0] line
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
      line  <= '0;
    end else if (clr) begin
      valid <= 1'b0;
    end else if (wr) begin
      valid <= 1'b1;
      tag   <= wr_tag;
      line  <= wr_line;
    end else if (inv) begin
      valid <= 1'b0;
    end
  end

  // R8: a clear leaves the entry empty on the next cycle
  a_r8_store_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !valid);
endmodule

// File: rtl/fpb_fill_engine.sv
`timescale 1ns/1ps
module fpb_fill_engine
  import fpb_pkg::*;
#(
  parameter int LA_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort,
  input  logic            start,
  input  logic [LA_W-1:0] start_addr,
  input  fill_tgt_e       start_tgt,
  input  logic [1:0]      ws_n,
  output logic            busy_q,
  output logic [LA_W-1:0] addr_q,
  output fill_tgt_e       tgt_q,
  output logic            rd,
  output logic [LA_W-1:0] rd_addr,
  output fill_tgt_e       cur_tgt,
  output logic            done
);
  logic [1:0] cnt_q;
  logic [1:0] cur_cnt;
  logic       active;

  always_comb begin
    cur_cnt = start ? 2'd0 : cnt_q;
    rd_addr = start ? start_addr : addr_q;
    cur_tgt = start ? start_tgt : tgt_q;
    active  = start | busy_q;
    rd      = active & ~abort;
    done    = rd & (cur_cnt == ws_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      tgt_q  <= TGT_C0;
    end else if (abort || done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (active) begin
      busy_q <= 1'b1;
      cnt_q  <= cur_cnt + 2'd1;
      addr_q <= rd_addr;
      tgt_q  <= cur_tgt;
    end
  end

  // R2: an in-flight read never counts past the selected wait window
  a_r2_wait_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= ws_n));
endmodule

// File: rtl/fpb_top.sv
`timescale 1ns/1ps
module fpb_top
  import fpb_pkg::*;
#(
  parameter int AW     = 16,
  parameter int WORD_W = 32,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ws_sel,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_code,
  input  logic [AW-1:0]     req_addr,
  output logic [WORD_W-1:0] rsp_data,
  output logic              fl_rd,
  output logic [AW-$clog2(LINE_W/8)-1:0] fl_addr,
  input  logic [LINE_W-1:0] fl_rdata
);
  localparam int NWORD = LINE_W / WORD_W;
  localparam int OFF_W = $clog2(LINE_W / 8);
  localparam int WSB   = $clog2(WORD_W / 8);
  localparam int WS_W  = $clog2(NWORD);
  localparam int LA_W  = AW - OFF_W;
  localparam int NBUF  = 3;

  logic [1:0]       ws_n;
  logic [LA_W-1:0]  req_line;
  logic [WS_W-1:0]  req_word;

  logic              buf_v    [NBUF];
  logic [LA_W-1:0]   buf_tag  [NBUF];
  logic [LINE_W-1:0] buf_line [NBUF];

  logic             e_busy_q, e_done, e_rd, start;
  logic [LA_W-1:0]  e_addr_q, e_rd_addr, start_addr;
  fill_tgt_e        e_tgt_q, e_cur_tgt, start_tgt;

  logic             cur_v, cur_buf;
  logic [LA_W-1:0]  cur_line, next_line;

  logic code_req, data_req, hit0, hit1, dhit, code_pend;
  logic start_code, start_data, start_pf, pf_need;
  logic fwd_code, fwd_data;
  logic [LINE_W-1:0] src_line;

  assign ws_n      = ws_decode(ws_sel);
  assign req_line  = req_addr[AW-1:OFF_W];
  assign req_word  = req_addr[OFF_W-1:WSB];
  assign next_line = cur_line + LA_W'(1);

  always_comb begin
    code_req  = req_valid & req_code;
    data_req  = req_valid & ~req_code;
    hit0      = buf_v[0] && (buf_tag[0] == req_line);
    hit1      = buf_v[1] && (buf_tag[1] == req_line);
    dhit      = buf_v[2] && (buf_tag[2] == req_line);
    code_pend = e_busy_q && (e_tgt_q != TGT_D) && (e_addr_q == req_line);
    pf_need   = cur_v
              && !(buf_v[0] && buf_tag[0] == next_line)
              && !(buf_v[1] && buf_tag[1] == next_line);

    start_code = code_req & ~hit0 & ~hit1 & ~code_pend & ~flush;
    start_data = data_req & ~dhit & ~e_busy_q & ~flush;
    start_pf   = pf_need & ~e_busy_q & ~start_code & ~start_data & ~flush;
    start      = start_code | start_data | start_pf;

    start_addr = (start_code | start_data) ? req_line : next_line;
    if (start_data)              start_tgt = TGT_D;
    else if (cur_v && !cur_buf)  start_tgt = TGT_C1;
    else                         start_tgt = TGT_C0;

    fwd_code = e_done && (e_cur_tgt != TGT_D) && (e_rd_addr == req_line);
    fwd_data = e_done && (e_cur_tgt == TGT_D) && (e_rd_addr == req_line);

    req_ready = (code_req & (hit0 | hit1 | fwd_code))
              | (data_req & (dhit | fwd_data));

    if (fwd_code | fwd_data) src_line = fl_rdata;
    else if (!req_code)      src_line = buf_line[2];
    else if (hit0)           src_line = buf_line[0];
    else                     src_line = buf_line[1];
    rsp_data = src_line[req_word*WORD_W +: WORD_W];
  end

  fpb_fill_engine #(.LA_W(LA_W)) eng_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (flush),
    .start     (start),
    .start_addr(start_addr),
    .start_tgt (start_tgt),
    .ws_n      (ws_n),
    .busy_q    (e_busy_q),
    .addr_q    (e_addr_q),
    .tgt_q     (e_tgt_q),
    .rd        (e_rd),
    .rd_addr   (e_rd_addr),
    .cur_tgt   (e_cur_tgt),
    .done      (e_done)
  );

  assign fl_rd   = e_rd;
  assign fl_addr = e_rd_addr;

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    fpb_line_store #(.LA_W(LA_W), .LINE_W(LINE_W)) store_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (flush),
      .inv    (start && (start_tgt == fill_tgt_e'(i))),
      .wr     (e_done && (e_cur_tgt == fill_tgt_e'(i))),
      .wr_tag (e_rd_addr),
      .wr_line(fl_rdata),
      .valid  (buf_v[i]),
      .tag    (buf_tag[i]),
      .line   (buf_line[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_v    <= 1'b0;
      cur_buf  <= 1'b0;
      cur_line <= '0;
    end else if (flush) begin
      cur_v <= 1'b0;
    end else if (code_req && req_ready) begin
      cur_v    <= 1'b1;
      cur_line <= req_line;
      cur_buf  <= fwd_code ? (e_cur_tgt == TGT_C1) : hit1;
    end
  end

  // R9: completion only while a request is presented
  a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  // R3: the two code buffers never hold the same line
  a_r3_code_bufs_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_v[0] && buf_v[1] && (buf_tag[0] == buf_tag[1])));

  // R8: a flush leaves every buffer empty
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(buf_v[0] || buf_v[1] || buf_v[2]));

  // R10: address held through a read unless a code miss restarts it
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && !e_done && !flush) |=> (!fl_rd || start_code || $stable(fl_addr)));

  // R6: a data fill leaves the code buffers as they were
  a_r6_data_fill_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (e_done && (e_cur_tgt == TGT_D) && !flush)
      |=> ($stable(buf_v[0]) && $stable(buf_v[1])
           && $stable(buf_tag[0]) && $stable(buf_tag[1])));
endmodule

// File: tb/fpb_top_tb.sv
`timescale 1ns/1ps
module fpb_top_tb_top;
  localparam int AW = 16;
  localparam int LA_W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   ws_sel = 2'd0;
  logic         flush = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_code = 1'b0;
  logic [15:0]  req_addr = '0;
  logic [31:0]  rsp_data;
  logic         fl_rd;
  logic [LA_W-1:0] fl_addr;
  logic [127:0] fl_rdata;

  int checks = 0;
  int fails = 0;
  int ws_exp = 0;

  always #10 clk = ~clk;

  fpb_top dut_i (
    .clk(clk), .rst_n(rst_n), .ws_sel(ws_sel), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_code(req_code),
    .req_addr(req_addr), .rsp_data(rsp_data), .fl_rd(fl_rd),
    .fl_addr(fl_addr), .fl_rdata(fl_rdata)
  );

  function automatic logic [31:0] word_of(input logic [LA_W-1:0] la, input logic [1:0] w);
    return {8'hA5, 6'd0, w, 4'h0, la};
  endfunction

  function automatic logic [31:0] exp_word(input logic [15:0] a);
    return word_of(a[15:4], a[3:2]);
  endfunction

  // array model: garbage until the address has been held ws cycles
  logic            prev_rd = 1'b0;
  logic [LA_W-1:0] prev_addr = '0;
  int              age_q = 0;
  int              cur_age;
  always_comb begin
    cur_age = (prev_rd && fl_addr == prev_addr) ? age_q + 1 : 0;
    if (fl_rd && cur_age >= ws_exp)
      fl_rdata = {word_of(fl_addr, 2'd3), word_of(fl_addr, 2'd2),
                  word_of(fl_addr, 2'd1), word_of(fl_addr, 2'd0)};
    else
      fl_rdata = {4{32'hDEAD_BEEF}};
  end
  always @(posedge clk) begin
    prev_rd   <= fl_rd;
    prev_addr <= fl_addr;
    age_q     <= cur_age;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (ws=%0d)", rq, act, exp, ws_exp);
    end
  endtask

  task automatic acc(input logic code, input logic [15:0] a, output int lat, output logic [31:0] d);
    bit got = 1'b0;
    lat = 0;
    d = '0;
    req_valid = 1'b1;
    req_code  = code;
    req_addr  = a;
    while (!got) begin
      #1;
      lat++;
      if (req_ready) begin
        got = 1'b1;
        d = rsp_data;
      end else if (lat > 400) begin
        got = 1'b1;
        chk(1'b0, "watchdog-request", 32'(lat), 32'd0);
      end
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // exp_lat < 0 skips the latency check
  task automatic do_chk(input logic code, input logic [15:0] a, input int exp_lat, input string rq);
    int lat;
    logic [31:0] d;
    acc(code, a, lat, d);
    if (exp_lat >= 0) chk(lat == exp_lat, rq, 32'(lat), 32'(exp_lat));
    chk(d == exp_word(a), "R4", d, exp_word(a));
  endtask

  task automatic pulse_flush();
    req_valid = 1'b0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    #(20 * 180000);
    chk(1'b0, "watchdog-global", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed = 32'h1234_5677;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R1 ready in reset", 32'(req_ready), 32'd0);
    chk(fl_rd == 1'b0, "R1 fl_rd in reset", 32'(fl_rd), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R1 ready after reset", 32'(req_ready), 32'd0);
    chk(fl_rd == 1'b0, "R1 fl_rd after reset", 32'(fl_rd), 32'd0);

    for (int k = 0; k < 4; k++) begin
      logic [15:0] base, dat, yl, xl;
      ws_sel = 2'(k);
      ws_exp = (k == 0) ? 0 : (k == 1) ? 1 : 3;
      base = 16'h1000 * 16'(k + 1);
      dat  = 16'h8000 + 16'h0040 * 16'(k);
      yl   = base + 16'h0800;
      xl   = base + 16'h0C00;
      pulse_flush();
      idle(8);

      // R2 cold miss, then R3 sequential run across four lines
      do_chk(1'b1, base, ws_exp + 1, "R2 code miss latency");
      for (int w = 1; w < 16; w++)
        do_chk(1'b1, base + 16'(4 * w), 1, "R3 sequential word");
      idle(8);

      // R5 data miss and hit, R6 code buffers untouched
      do_chk(1'b0, dat, ws_exp + 1, "R5 data miss latency");
      do_chk(1'b0, dat + 16'h4, 1, "R5 data hit latency");
      do_chk(1'b1, base + 16'h34, 1, "R6 code line kept");
      do_chk(1'b1, base + 16'h40, 1, "R6 prefetched line kept");
      idle(8);

      // R8 flush empties everything
      pulse_flush();
      idle(2);
      do_chk(1'b1, base + 16'h30, ws_exp + 1, "R8 code after flush");
      idle(8);
      do_chk(1'b0, dat, ws_exp + 1, "R8 data after flush");
      idle(8);

      // R7 miss during a prefetch abandons it
      do_chk(1'b1, yl, ws_exp + 1, "R2 code miss latency");
      idle(1);
      do_chk(1'b1, xl, ws_exp + 1, "R7 miss over prefetch");
      do_chk(1'b1, xl + 16'h4, 1, "R3 sequential word");
      do_chk(1'b1, yl + 16'h10, ws_exp + 1, "R7 miss over prefetch");
      idle(8);

      // R4 near-exhaustive words: 16 lines sequential
      for (int w = 0; w < 64; w++)
        do_chk(1'b1, 16'h9000 + 16'(4 * w), -1, "R4");
      idle(8);

      // R4 mixed code/data sweep
      for (int i = 0; i < 60; i++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        do_chk(seed[20], {6'b101000, seed[15:8], 2'b00}, -1, "R4");
        if (seed[24]) idle(1);
      end
      idle(8);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule